// File: doc/BRIEF.md
# Flag-Setting 32-bit Arithmetic Unit

This block is the arithmetic core of an integer execution stage. It takes two 32-bit operands, called N-side and M-side, and an operation code. It forms a 32-bit result with one shared adder, in the same cycle. The operations are add, add with carry, subtract, subtract with carry and reverse subtract.

Next to the adder sits a 32-bit status word. Its top nibble holds four condition flags: negative, zero, carry and overflow. An operation rewrites the flags only when it carries a set-flags request. The two carry-using operations take their carry-in from the stored carry flag. Because of this, a wide sum can be built from several 32-bit steps: a flag-setting add of the low words, then flag-setting add-with-carry steps for the higher words.

The operand interface has no back-pressure. The unit accepts an operation in every cycle in which `op_valid` is high, so there is no ready signal. `result` follows the inputs combinationally, whether or not `op_valid` is high. The status word changes only at a rising clock edge. A synchronous, active-high reset clears it.

Top module: `flag_alu`

## Requirements
- R1: A clock edge with `rst` high sets `status` to 0x00000000.
- R2: With `op_code` 0 (add), `result` is `opnd_n + opnd_m` modulo 2^32.
- R3: With `op_code` 1 (add with carry), `result` is `opnd_n + opnd_m + C`, where C is `status[29]` as it stood before the edge that captures this operation.
- R4: With `op_code` 2 (subtract), `result` is `opnd_n - opnd_m`, computed as `opnd_n + ~opnd_m + 1`. The carry flag is the carry out of that sum, so C=1 means no borrow.
- R5: With `op_code` 3 (subtract with carry), `result` is `opnd_n + ~opnd_m + C`, using the stored C.
- R6: With `op_code` 4 (reverse subtract), `result` is `opnd_m - opnd_n`, computed as `opnd_m + ~opnd_n + 1`.
- R7: After a flag-setting operation, `status[31]` (N) equals bit 31 of that operation's result.
- R8: After a flag-setting operation, `status[30]` (Z) is 1 exactly when all 32 result bits are zero.
- R9: After a flag-setting operation, `status[29]` (C) is the carry out of bit 31 of the adder.
- R10: After a flag-setting operation, `status[28]` (V) is 1 exactly when the adder's signed sum overflows.
- R11: At a clock edge where `op_valid` or `set_flags` is low, `status` keeps its value, and `result` is still produced.
- R12: Bits 27 down to 0 of `status` always read as zero.
- R13: A flag-setting add of the low words, followed by a flag-setting add-with-carry of the high words, yields the exact 64-bit sum.
- R14: The unused `op_code` values 5, 6 and 7 behave exactly as add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the status word updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the status word |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation select; encodings are given in R2 to R6 and R14 |
| set_flags | input | 1 | Request to write the condition flags |
| opnd_n | input | 32 | First operand |
| opnd_m | input | 32 | Second operand |
| result | output | 32 | Combinational arithmetic result |
| status | output | 32 | Status word: N, Z, C, V in bits 31 to 28, zeros below |

## Verification
Corrupt stored flags show at `status` one cycle after the operation that wrote them. A wrong carry flag shows up again in the very next add-with-carry or subtract-with-carry, because it then changes `result` in the same cycle. The bench therefore compares `result` in every cycle against a behavioural model that keeps its own copy of the flags. It compares every `status` bit after every edge, so a stray flag write or a missed hold is reported within one clock. Chained 64-bit sums check the carry hand-off across two operations.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_RSB = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
    logic ovf;
  } cond_flags_t;

  localparam int unsigned FLAG_COUNT = 4;

endpackage

// File: rtl/alu_operand_mux.sv
module alu_operand_mux
  import flag_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [2:0]       op_code,
  input  logic [WIDTH-1:0] opnd_n,
  input  logic [WIDTH-1:0] opnd_m,
  input  logic             carry_stored,
  output logic [WIDTH-1:0] add_a,
  output logic [WIDTH-1:0] add_b,
  output logic             add_cin
);

  always_comb begin
    add_a   = opnd_n;
    add_b   = opnd_m;
    add_cin = 1'b0;
    case (op_code)
      OP_ADC: begin
        add_cin = carry_stored;
      end
      OP_SUB: begin
        add_b   = ~opnd_m;
        add_cin = 1'b1;
      end
      OP_SBC: begin
        add_b   = ~opnd_m;
        add_cin = carry_stored;
      end
      OP_RSB: begin
        add_a   = opnd_m;
        add_b   = ~opnd_n;
        add_cin = 1'b1;
      end
      default: begin
        // plain add; unused encodings fall here (R14)
        add_cin = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             carry_into_msb,
  output logic             carry_out
);

  localparam int unsigned LOW = WIDTH - 1;

  logic [LOW:0] low_sum;
  logic         a_top;
  logic         b_top;

  assign low_sum = {1'b0, a[LOW-1:0]} + {1'b0, b[LOW-1:0]} + {{LOW{1'b0}}, cin};
  assign a_top   = a[WIDTH-1];
  assign b_top   = b[WIDTH-1];

  assign carry_into_msb = low_sum[LOW];
  assign sum            = {a_top ^ b_top ^ carry_into_msb, low_sum[LOW-1:0]};
  assign carry_out      = (a_top & b_top) | (a_top & carry_into_msb) | (b_top & carry_into_msb);

  // The split low/top adder must agree with a single full-width sum (R9).
  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      p_carry_chain_r9: assert ({carry_out, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
        else $error("split adder disagrees with full-width sum");
    end
  end

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import flag_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] sum,
  input  logic             carry_into_msb,
  input  logic             carry_out,
  output cond_flags_t      flags
);

  always_comb begin
    flags.neg   = sum[WIDTH-1];
    flags.zero  = (sum == '0);
    flags.carry = carry_out;
    flags.ovf   = carry_into_msb ^ carry_out;
  end

endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
  import flag_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  cond_flags_t      flags_in,
  output cond_flags_t      flags_q,
  output logic [WIDTH-1:0] status
);

  localparam int unsigned PAD = WIDTH - FLAG_COUNT;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else if (wr_en) begin
      flags_q <= flags_in;
    end
  end

  assign status = {flags_q, {PAD{1'b0}}};

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (status == '0))
    else $error("status not cleared by reset");

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(flags_q))
    else $error("flags changed without a write");

  p_capture_r9: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (flags_q == $past(flags_in)))
    else $error("flags not captured on write");

  p_reserved_zero_r12: assert property (@(posedge clk) disable iff (rst)
    status[PAD-1:0] == '0)
    else $error("reserved status bits nonzero");

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic             set_flags,
  input  logic [WIDTH-1:0] opnd_n,
  input  logic [WIDTH-1:0] opnd_m,
  output logic [WIDTH-1:0] result,
  output logic [WIDTH-1:0] status
);

  localparam int unsigned BIT_N = WIDTH - 1;
  localparam int unsigned BIT_Z = WIDTH - 2;

  logic [WIDTH-1:0] add_a;
  logic [WIDTH-1:0] add_b;
  logic             add_cin;
  logic             c_msb_in;
  logic             c_out;
  cond_flags_t      next_flags;
  cond_flags_t      cur_flags;
  logic             flag_wr;

  assign flag_wr = op_valid & set_flags;

  alu_operand_mux #(.WIDTH(WIDTH)) u_mux (
    .op_code      (op_code),
    .opnd_n       (opnd_n),
    .opnd_m       (opnd_m),
    .carry_stored (cur_flags.carry),
    .add_a        (add_a),
    .add_b        (add_b),
    .add_cin      (add_cin)
  );

  alu_adder #(.WIDTH(WIDTH)) u_add (
    .a              (add_a),
    .b              (add_b),
    .cin            (add_cin),
    .sum            (result),
    .carry_into_msb (c_msb_in),
    .carry_out      (c_out)
  );

  alu_flag_gen #(.WIDTH(WIDTH)) u_flags (
    .sum            (result),
    .carry_into_msb (c_msb_in),
    .carry_out      (c_out),
    .flags          (next_flags)
  );

  alu_status_reg #(.WIDTH(WIDTH)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (flag_wr),
    .flags_in (next_flags),
    .flags_q  (cur_flags),
    .status   (status)
  );

  p_neg_follows_r7: assert property (@(posedge clk) disable iff (rst)
    flag_wr |=> (status[BIT_N] == $past(result[WIDTH-1])))
    else $error("N flag does not follow result sign");

  p_zero_follows_r8: assert property (@(posedge clk) disable iff (rst)
    flag_wr |=> (status[BIT_Z] == ($past(result) == '0)))
    else $error("Z flag does not follow zero result");

  p_port_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !flag_wr |=> $stable(status))
    else $error("status moved without a flag write");

endmodule

// File: tb/sim_flag_alu.sv
module sim_flag_alu;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [2:0]  op_code;
  logic        set_flags;
  logic [31:0] opnd_n;
  logic [31:0] opnd_m;
  logic [31:0] result;
  logic [31:0] status;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [31:0] m_st;       // model status word
  logic [31:0] last_res;   // model result of the last op

  always #4 clk = ~clk;    // 125 MHz

  flag_alu u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .set_flags(set_flags), .opnd_n(opnd_n), .opnd_m(opnd_m),
    .result(result), .status(status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One operation; checks result this cycle and status after the edge.
  task automatic run(input logic [2:0] op, input logic [31:0] n, input logic [31:0] m,
                     input bit sf, input bit vld);
    logic [31:0] a, b, r;
    logic        ci, co, v;
    logic [32:0] s;
    string       rtag;
    @(negedge clk);
    op_code = op; opnd_n = n; opnd_m = m; set_flags = sf; op_valid = vld;
    case (op)
      3'd1: begin a = n; b = m;  ci = m_st[29]; rtag = "R3 adc"; end
      3'd2: begin a = n; b = ~m; ci = 1'b1;     rtag = "R4 sub"; end
      3'd3: begin a = n; b = ~m; ci = m_st[29]; rtag = "R5 sbc"; end
      3'd4: begin a = m; b = ~n; ci = 1'b1;     rtag = "R6 rsb"; end
      3'd0: begin a = n; b = m;  ci = 1'b0;     rtag = "R2 add"; end
      default: begin a = n; b = m; ci = 1'b0;   rtag = "R14 unused code"; end
    endcase
    s  = {1'b0, a} + {1'b0, b} + {32'd0, ci};
    r  = s[31:0];
    co = s[32];
    v  = (a[31] == b[31]) && (r[31] != a[31]);
    #1;
    chk(rtag, result, r);
    last_res = r;
    @(posedge clk);
    if (vld && sf) m_st = {r[31], (r == 32'd0), co, v, 28'd0};
    @(negedge clk);
    if (vld && sf) begin
      chk("R7 N flag", {31'd0, status[31]}, {31'd0, m_st[31]});
      chk("R8 Z flag", {31'd0, status[30]}, {31'd0, m_st[30]});
      chk("R9 C flag", {31'd0, status[29]}, {31'd0, m_st[29]});
      chk("R10 V flag", {31'd0, status[28]}, {31'd0, m_st[28]});
    end else begin
      chk("R11 status held", status, m_st);
    end
    chk("R12 reserved bits", {4'd0, status[27:0]}, 32'd0);
  endtask

  task automatic add64(input logic [63:0] x, input logic [63:0] y);
    logic [31:0] lo;
    run(3'd0, x[31:0], y[31:0], 1'b1, 1'b1);
    lo = last_res;
    run(3'd1, x[63:32], y[63:32], 1'b1, 1'b1);
    total++;
    if ({last_res, lo} !== x + y) begin
      bad++;
      $display("FAIL R13 64-bit chain: actual=%h expected=%h", {last_res, lo}, x + y);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; op_valid = 0; op_code = 0; set_flags = 0; opnd_n = 0; opnd_m = 0;
    m_st = 32'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset state", status, 32'd0);
    rst = 1'b0;

    run(3'd0, 32'd5, 32'hFFFFFFFB, 1'b1, 1'b1);        // 5 + -5: Z, C
    run(3'd0, 32'hFF000000, 32'hFF000000, 1'b1, 1'b1); // carry out
    run(3'd0, 32'h7FFFFFFF, 32'd1, 1'b1, 1'b1);        // signed overflow
    run(3'd2, 32'h80000000, 32'd1, 1'b1, 1'b1);        // overflow on subtract
    run(3'd2, 32'd5, 32'd6, 1'b1, 1'b1);               // negative, borrow
    run(3'd2, 32'd6, 32'd6, 1'b1, 1'b1);               // zero, no borrow
    run(3'd1, 32'd1, 32'd16, 1'b0, 1'b1);              // adc uses stored C=1
    run(3'd3, 32'd10, 32'd3, 1'b1, 1'b1);              // sbc with C=1
    run(3'd0, 32'd1, 32'd1, 1'b1, 1'b1);               // clear C
    run(3'd3, 32'd10, 32'd3, 1'b1, 1'b1);              // sbc with C=0
    run(3'd4, 32'd3, 32'd10, 1'b1, 1'b1);              // rsb 10-3
    run(3'd4, 32'd10, 32'd3, 1'b1, 1'b1);              // rsb 3-10
    run(3'd0, 32'hFFFFFFFF, 32'd1, 1'b1, 1'b0);        // not valid: hold (R11)
    run(3'd2, 32'd0, 32'd0, 1'b0, 1'b1);               // no set_flags: hold (R11)
    run(3'd5, 32'h12345678, 32'h11111111, 1'b1, 1'b1); // R14
    run(3'd6, 32'hFFFFFFFF, 32'd1, 1'b1, 1'b1);        // R14
    run(3'd7, 32'h80000000, 32'h80000000, 1'b1, 1'b1); // R14

    add64(64'h00000001_FFFFFFFF, 64'h00000002_00000001);
    add64(64'h7FFFFFFF_FFFFFFFF, 64'h00000000_00000001);
    for (int i = 0; i < 6; i++) add64({$urandom, $urandom}, {$urandom, $urandom});

    for (int i = 0; i < 300; i++)
      run(3'($urandom_range(0, 7)), $urandom, $urandom, 1'($urandom), 1'($urandom));

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    m_st = 32'd0;
    chk("R1 reset mid-run", status, 32'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule